// File: doc/BRIEF.md
# External Data Memory Access Controller

This block carries out the external-data move operations of a small 8-bit microcontroller core. The core gives it one request at a time. A request holds an addressing mode (a 16-bit pointer or an 8-bit indirect register), a 16-bit address, a read/write flag and a write byte. Alongside the request comes a routing configuration bit, `ext_only`. From the mode, the address and that bit, the block decides where the access goes. It is served either by a 768-byte expanded RAM held inside the block, or by an external memory bus cycle. That bus uses a high-address port, a multiplexed address/data port, an address-latch strobe and active-low read and write strobes.

The block runs as one sequencer with six named states:

- `ST_IDLE`: waits for a request.
- `ST_INT_DONE`: completes an internal access in one cycle.
- `ST_EXT_ADDR`: drives the address and raises the latch strobe.
- `ST_EXT_HOLD`: drops the latch strobe while the address stays on the bus.
- `ST_EXT_STROBE`: holds RD# or WR# low for `STROBE_CYC` clocks.
- `ST_EXT_END`: releases the bus and signals completion.

The transitions are:

- `ST_IDLE` to `ST_INT_DONE`, on an accepted internal request.
- `ST_IDLE` to `ST_EXT_ADDR`, on an accepted external request.
- `ST_EXT_ADDR` to `ST_EXT_HOLD`, always.
- `ST_EXT_HOLD` to `ST_EXT_STROBE`, always.
- `ST_EXT_STROBE` to `ST_EXT_END`, when the strobe counter reaches its last count.
- `ST_INT_DONE` to `ST_IDLE`, always.
- `ST_EXT_END` to `ST_IDLE`, always.

The core waits on `busy` and collects the result on the `done` pulse.

Top module: `xdata_access_ctrl`

## Requirements
- R1: While reset is asserted, all of the following hold: `rd_n` and `wr_n` are 1, `ale` is 0, `ad_oe` is 0 (multiplexed port released), `busy` and `done` are 0, and `hi_port` is 8'hFF.
- R2: A request is accepted on a rising edge where `req_valid` is 1 and `busy` is 0. With `req_mode`=0 (16-bit pointer), `ext_only`=0 and an address below 0x0300, the access goes to the expanded RAM at that address. In that case `ale`, `rd_n` and `wr_n` stay inactive, and `done` is high for the one cycle right after the accepting edge. For a read, `rdata` carries the stored byte during that `done` cycle.
- R3: With `req_mode`=0, `ext_only`=0 and an address of 0x0300 or above, the access runs an external bus cycle at the full 16-bit address.
- R4: With `req_mode`=1 (8-bit indirect) and `ext_only`=0, the access never uses the external bus. It reaches expanded RAM location `req_addr[7:0]` (0x000 to 0x0FF), whatever `req_addr[15:8]` holds.
- R5: With `ext_only`=1, every access runs an external bus cycle, in both addressing modes, and the expanded RAM is not touched.
- R6: An external cycle runs these steps in order, counting from the accepting edge:
  - For one cycle, `ale`=1 and `ad_oe`=1 with the low address byte on `ad_out`.
  - For one cycle, `ale`=0 with the address still driven.
  - For `STROBE_CYC` cycles (default 3), one strobe is low.
  - For one cycle, `done`=1 with both strobes high. This is 2+`STROBE_CYC` cycles after the cycle that follows the accepting edge.
- R7: On an external write, `wr_n` is low and `ad_out` carries the write byte with `ad_oe`=1. On an external read, `rd_n` is low with `ad_oe`=0. The byte on `ad_in` is sampled at the edge that ends the last low cycle of `rd_n`, and it is presented on `rdata` during `done`.
- R8: Each external access in pointer mode loads `req_addr[15:8]` into `hi_port`, and `hi_port` keeps that value afterwards. An external indirect access leaves `hi_port` unchanged, and that held byte forms the high half of its bus address.
- R9: `busy` is high from the accepting edge through the `done` cycle, and only one access is outstanding at a time. A request presented while `busy` is high is ignored: it writes no memory and causes no extra `done`.
- R10: `rd_n` and `wr_n` are never low at the same time. `ale` is high only while the multiplexed port is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_mode | input | 1 | 0 = 16-bit pointer, 1 = 8-bit indirect |
| req_addr | input | 16 | Access address (indirect mode uses bits 7:0) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write byte |
| ext_only | input | 1 | Routing configuration bit: 1 sends every access to the external bus |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read byte, valid while `done` is high |
| hi_port | output | 8 | High address byte port |
| ad_out | output | 8 | Multiplexed address/data output |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| ad_in | input | 8 | Multiplexed port input from memory |
| ale | output | 1 | Address latch strobe, active high |
| wr_n | output | 1 | External write strobe, active low |
| rd_n | output | 1 | External read strobe, active low |

## Verification
The driver records, for every accepted request, the cycle right after its accepting edge, and the monitor compares `done` against that mark. An internal access must complete in that very cycle. An external one must complete 2+`STROBE_CYC` cycles later. The monitor samples on the falling edge, so strobe-low cycles, latch-strobe cycles, the latched bus address and the write byte are all counted between the accepting edge and `done`, and are compared when `done` appears. A bench-side memory answers read strobes, and a shadow model of both memories supplies the expected read bytes.

// File: rtl/xdata_pkg.sv
package xdata_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    typedef enum logic {
        AM_PTR16 = 1'b0,
        AM_IND8  = 1'b1
    } addr_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_INT_DONE   = 3'd1,
        ST_EXT_ADDR   = 3'd2,
        ST_EXT_HOLD   = 3'd3,
        ST_EXT_STROBE = 3'd4,
        ST_EXT_END    = 3'd5
    } seq_state_e;

endpackage

// File: rtl/xdata_route.sv
module xdata_route
    import xdata_pkg::*;
#(
    parameter int ERAM_BYTES = 768,
    localparam int RAM_AW = $clog2(ERAM_BYTES)
) (
    input  logic              mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ext_only,
    output logic              go_ext,
    output logic [RAM_AW-1:0] ram_addr
);

    // Pointer-mode accesses at or above this address leave the chip
    localparam logic [ADDR_W-1:0] EXT_BASE = ADDR_W'(ERAM_BYTES);

    always_comb begin
        unique case (addr_mode_e'(mode))
            AM_PTR16: begin
                go_ext   = ext_only | (addr >= EXT_BASE);
                ram_addr = addr[RAM_AW-1:0];
            end
            AM_IND8: begin
                go_ext   = ext_only;
                ram_addr = RAM_AW'(addr[7:0]);
            end
            default: begin
                go_ext   = 1'b1;
                ram_addr = '0;
            end
        endcase
    end

endmodule

// File: rtl/xdata_eram.sv
module xdata_eram
    import xdata_pkg::*;
#(
    parameter int DEPTH = 768,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        if (re) begin
            rdata <= mem[addr];
        end
    end

endmodule

// File: rtl/xdata_seq.sv
module xdata_seq
    import xdata_pkg::*;
#(
    parameter int STROBE_CYC = 3,
    localparam int CNT_W = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1,
    localparam int RUN_W = $clog2(STROBE_CYC + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              go_ext,
    input  logic              is_write,
    input  logic              is_ptr16,
    input  logic [DATA_W-1:0] lo_addr,
    input  logic [DATA_W-1:0] hi_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] ram_q,
    input  logic [DATA_W-1:0] ad_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] hi_port,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              ale,
    output logic              wr_n,
    output logic              rd_n
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STROBE_CYC - 1);

    seq_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] lo_q;
    logic [DATA_W-1:0] wd_q;
    logic              wr_q;
    logic [DATA_W-1:0] hi_q;
    logic [DATA_W-1:0] rd_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (accept) state_d = go_ext ? ST_EXT_ADDR : ST_INT_DONE;
            ST_INT_DONE:   state_d = ST_IDLE;
            ST_EXT_ADDR:   state_d = ST_EXT_HOLD;
            ST_EXT_HOLD:   state_d = ST_EXT_STROBE;
            ST_EXT_STROBE: if (cnt_q == LAST_CNT) state_d = ST_EXT_END;
            ST_EXT_END:    state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Captured request, strobe counter, high-address latch, read byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lo_q  <= '0;
            wd_q  <= '0;
            wr_q  <= 1'b0;
            hi_q  <= '1;
            rd_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && accept) begin
                lo_q <= lo_addr;
                wd_q <= wdata;
                wr_q <= is_write;
                if (go_ext && is_ptr16) begin
                    hi_q <= hi_addr;
                end
            end
            if (state_q == ST_EXT_HOLD) begin
                cnt_q <= '0;
            end else if (state_q == ST_EXT_STROBE) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == LAST_CNT && !wr_q) begin
                    rd_q <= ad_in;
                end
            end
            if (state_q == ST_INT_DONE && !wr_q) begin
                rd_q <= ram_q;
            end
        end
    end

    // Outputs
    always_comb begin
        busy    = 1'b1;
        done    = 1'b0;
        ale     = 1'b0;
        ad_oe   = 1'b0;
        ad_out  = '0;
        rd_n    = 1'b1;
        wr_n    = 1'b1;
        rdata   = rd_q;
        hi_port = hi_q;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
            end
            ST_INT_DONE: begin
                done = 1'b1;
                if (!wr_q) rdata = ram_q;
            end
            ST_EXT_ADDR: begin
                ale    = 1'b1;
                ad_oe  = 1'b1;
                ad_out = lo_q;
            end
            ST_EXT_HOLD: begin
                ad_oe  = 1'b1;
                ad_out = lo_q;
            end
            ST_EXT_STROBE: begin
                if (wr_q) begin
                    wr_n   = 1'b0;
                    ad_oe  = 1'b1;
                    ad_out = wd_q;
                end else begin
                    rd_n = 1'b0;
                end
            end
            ST_EXT_END: begin
                done = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

    // Checks kept beside the sequencer
    logic [RUN_W-1:0] strobe_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_run <= '0;
        end else if (!rd_n || !wr_n) begin
            strobe_run <= strobe_run + 1'b1;
        end else begin
            strobe_run <= '0;
        end
    end

    a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    a_r10_ale_needs_drive: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> ad_oe);

    a_r6_ale_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (!ale && ad_oe && rd_n && wr_n));

    a_r6_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_n) || $rose(wr_n)) |-> (strobe_run == RUN_W'(STROBE_CYC) && done));

    a_r7_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

endmodule

// File: rtl/xdata_access_ctrl.sv
module xdata_access_ctrl
    import xdata_pkg::*;
#(
    parameter int ERAM_BYTES = 768,
    parameter int STROBE_CYC = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_mode,
    input  logic [15:0] req_addr,
    input  logic        req_write,
    input  logic [7:0]  req_wdata,
    input  logic        ext_only,
    output logic        busy,
    output logic        done,
    output logic [7:0]  rdata,
    output logic [7:0]  hi_port,
    output logic [7:0]  ad_out,
    output logic        ad_oe,
    input  logic [7:0]  ad_in,
    output logic        ale,
    output logic        wr_n,
    output logic        rd_n
);

    localparam int RAM_AW = $clog2(ERAM_BYTES);

    logic              accept;
    logic              go_ext;
    logic [RAM_AW-1:0] ram_addr;
    logic [DATA_W-1:0] ram_q;
    logic              ram_we;
    logic              ram_re;

    assign accept = req_valid & ~busy;
    assign ram_we = accept & ~go_ext &  req_write;
    assign ram_re = accept & ~go_ext & ~req_write;

    xdata_route #(.ERAM_BYTES(ERAM_BYTES)) route_i (
        .mode     (req_mode),
        .addr     (req_addr),
        .ext_only (ext_only),
        .go_ext   (go_ext),
        .ram_addr (ram_addr)
    );

    xdata_eram #(.DEPTH(ERAM_BYTES)) eram_i (
        .clk   (clk),
        .we    (ram_we),
        .re    (ram_re),
        .addr  (ram_addr),
        .wdata (req_wdata),
        .rdata (ram_q)
    );

    xdata_seq #(.STROBE_CYC(STROBE_CYC)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .go_ext   (go_ext),
        .is_write (req_write),
        .is_ptr16 (req_mode == AM_PTR16),
        .lo_addr  (req_addr[7:0]),
        .hi_addr  (req_addr[15:8]),
        .wdata    (req_wdata),
        .ram_q    (ram_q),
        .ad_in    (ad_in),
        .busy     (busy),
        .done     (done),
        .rdata    (rdata),
        .hi_port  (hi_port),
        .ad_out   (ad_out),
        .ad_oe    (ad_oe),
        .ale      (ale),
        .wr_n     (wr_n),
        .rd_n     (rd_n)
    );

    a_r2_internal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !ext_only && req_mode == AM_PTR16 && req_addr < 16'h0300)
            |=> (done && rd_n && wr_n && !ale));

    a_r3_high_goes_out: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_mode == AM_PTR16 && req_addr >= 16'h0300) |=> (ale && !done));

    a_r4_indirect_stays_in: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !ext_only && req_mode == AM_IND8) |=> (done && rd_n && wr_n && !ale));

    a_r5_cfg_forces_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ext_only) |=> (ale && !done));

    a_r8_indirect_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_mode == AM_IND8) |=> $stable(hi_port));

    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && busy && !done) |=> busy);

endmodule

// File: tb/xdata_access_ctrl_tb_top.sv
module xdata_access_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int STROBE_CYC = 3;
    localparam int ERAM_BYTES = 768;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_mode = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic        ext_only = 1'b0;
    logic        busy, done, ad_oe, ale, wr_n, rd_n;
    logic [7:0]  rdata, hi_port, ad_out;
    logic [7:0]  ad_in = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xdata_access_ctrl #(.ERAM_BYTES(ERAM_BYTES), .STROBE_CYC(STROBE_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
        .ext_only(ext_only), .busy(busy), .done(done), .rdata(rdata),
        .hi_port(hi_port), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
        .ale(ale), .wr_n(wr_n), .rd_n(rd_n)
    );

    typedef struct {
        bit          ext;
        bit          wr;
        logic [7:0]  exp_rd;
        logic [15:0] exp_addr;
        logic [7:0]  exp_wd;
        int          acc;
    } item_t;

    item_t       q[$];
    string       tq[$];
    logic [7:0]  ext_mem [int];
    logic [7:0]  ext_shadow [int];
    logic [7:0]  int_shadow [int];
    logic [7:0]  exp_hi = 8'hFF;
    int          cyc = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          reported = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic logic [7:0] ext_default(input int a);
        return 8'h5A ^ a[7:0];
    endfunction

    // Driver: computes the expected outcome and pushes it before the accepting edge
    task automatic do_op(input bit m, input logic [15:0] a, input bit w,
                         input logic [7:0] d, input bit c, input string tag);
        item_t it;
        int    idx;
        @(negedge clk);
        while (busy) @(negedge clk);
        it.ext = c || (m == 1'b0 && a >= 16'(ERAM_BYTES));
        it.wr  = w;
        it.exp_wd = d;
        if (it.ext && m == 1'b0) exp_hi = a[15:8];
        it.exp_addr = (m == 1'b0) ? a : {exp_hi, a[7:0]};
        it.exp_rd = 8'h00;
        if (it.ext) begin
            idx = int'(it.exp_addr);
            if (w) ext_shadow[idx] = d;
            else it.exp_rd = ext_shadow.exists(idx) ? ext_shadow[idx] : ext_default(idx);
        end else begin
            idx = (m == 1'b0) ? int'(a[9:0]) : int'(a[7:0]);
            if (w) int_shadow[idx] = d;
            else it.exp_rd = int_shadow.exists(idx) ? int_shadow[idx] : 8'h00;
        end
        it.acc = cyc + 1;
        q.push_back(it);
        tq.push_back(tag);
        ext_only  = c;
        req_mode  = m;
        req_addr  = a;
        req_write = w;
        req_wdata = d;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor and external memory responder
    int          ale_cnt = 0, rd_cnt = 0, wr_cnt = 0;
    logic [15:0] lat_a = '0;
    logic [7:0]  cap_wd = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ale) begin
                lat_a = {hi_port, ad_out};
                ale_cnt++;
            end
            if (!rd_n) begin
                rd_cnt++;
                ad_in <= ext_mem.exists(int'(lat_a)) ? ext_mem[int'(lat_a)]
                                                     : ext_default(int'(lat_a));
            end
            if (!wr_n) begin
                wr_cnt++;
                cap_wd = ad_out;
                ext_mem[int'(lat_a)] = ad_out;
            end
            if (done) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected done", 1, 0);
                end else begin
                    item_t it;
                    string tag;
                    it  = q.pop_front();
                    tag = tq.pop_front();
                    if (it.ext) begin
                        chk(cyc - it.acc == 2 + STROBE_CYC, "R6", "external latency",
                            cyc - it.acc, 2 + STROBE_CYC);
                        chk(ale_cnt == 1, tag, "latch strobe count", ale_cnt, 1);
                        chk(lat_a == it.exp_addr, tag, "bus address", lat_a, it.exp_addr);
                        if (it.wr) begin
                            chk(wr_cnt == STROBE_CYC && rd_cnt == 0, "R7", "write strobe cycles",
                                wr_cnt, STROBE_CYC);
                            chk(cap_wd == it.exp_wd, "R7", "write byte", cap_wd, it.exp_wd);
                        end else begin
                            chk(rd_cnt == STROBE_CYC && wr_cnt == 0, "R7", "read strobe cycles",
                                rd_cnt, STROBE_CYC);
                        end
                    end else begin
                        chk(cyc == it.acc, "R2", "internal latency", cyc - it.acc, 0);
                        chk(ale_cnt + rd_cnt + wr_cnt == 0, tag, "bus activity",
                            ale_cnt + rd_cnt + wr_cnt, 0);
                    end
                    if (!it.wr) begin
                        chk(rdata == it.exp_rd, tag, "read byte", rdata, it.exp_rd);
                    end
                end
                ale_cnt = 0;
                rd_cnt  = 0;
                wr_cnt  = 0;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "R9", "watchdog expired", 0, 1);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(rd_n && wr_n, "R1", "strobes in reset", {rd_n, wr_n}, 2'b11);
        chk(!ale && !ad_oe, "R1", "latch/drive in reset", {ale, ad_oe}, 0);
        chk(!busy && !done, "R1", "busy/done in reset", {busy, done}, 0);
        chk(hi_port == 8'hFF, "R1", "high port in reset", hi_port, 8'hFF);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: pointer mode below the threshold, including the last RAM byte
        do_op(1'b0, 16'h0123, 1'b1, 8'hA5, 1'b0, "R2");
        do_op(1'b0, 16'h0123, 1'b0, 8'h00, 1'b0, "R2");
        do_op(1'b0, 16'h02FF, 1'b1, 8'h3E, 1'b0, "R2");
        do_op(1'b0, 16'h02FF, 1'b0, 8'h00, 1'b0, "R2");
        do_op(1'b0, 16'h0245, 1'b1, 8'h24, 1'b0, "R2");
        do_op(1'b0, 16'h0010, 1'b1, 8'h61, 1'b0, "R2");

        // R3: pointer mode at and above the threshold
        do_op(1'b0, 16'h0300, 1'b1, 8'hC3, 1'b0, "R3");
        do_op(1'b0, 16'h0300, 1'b0, 8'h00, 1'b0, "R3");
        do_op(1'b0, 16'hFFFF, 1'b1, 8'h96, 1'b0, "R3");
        do_op(1'b0, 16'hFFFF, 1'b0, 8'h00, 1'b0, "R3");
        do_op(1'b0, 16'h8001, 1'b0, 8'h00, 1'b0, "R3");
        chk(hi_port == 8'h80, "R8", "high port after pointer access", hi_port, 8'h80);

        // R4: indirect mode stays inside and uses only the low byte
        do_op(1'b1, 16'h1245, 1'b1, 8'h77, 1'b0, "R4");
        do_op(1'b0, 16'h0045, 1'b0, 8'h00, 1'b0, "R4");
        do_op(1'b0, 16'h0245, 1'b0, 8'h00, 1'b0, "R4");
        do_op(1'b1, 16'hFF45, 1'b0, 8'h00, 1'b0, "R4");
        chk(hi_port == 8'h80, "R8", "high port after internal indirect", hi_port, 8'h80);

        // R5: configuration bit forces the bus in both modes
        do_op(1'b0, 16'h0010, 1'b1, 8'hE7, 1'b1, "R5");
        do_op(1'b0, 16'h0010, 1'b0, 8'h00, 1'b0, "R5");
        do_op(1'b0, 16'h0010, 1'b0, 8'h00, 1'b1, "R5");
        do_op(1'b0, 16'h5510, 1'b1, 8'h42, 1'b1, "R5");
        do_op(1'b1, 16'h0020, 1'b1, 8'h19, 1'b1, "R8");
        chk(hi_port == 8'h55, "R8", "high port held by indirect", hi_port, 8'h55);
        do_op(1'b1, 16'h0020, 1'b0, 8'h00, 1'b1, "R8");

        // R9: a request during an external cycle is ignored
        do_op(1'b0, 16'h0100, 1'b1, 8'h11, 1'b0, "R9");
        do_op(1'b0, 16'h4000, 1'b0, 8'h00, 1'b0, "R9");
        ext_only  = 1'b0;
        req_mode  = 1'b0;
        req_addr  = 16'h0100;
        req_write = 1'b1;
        req_wdata = 8'h99;
        req_valid = 1'b1;
        chk(busy, "R9", "busy during external cycle", busy, 1);
        repeat (2) @(negedge clk);
        req_valid = 1'b0;
        do_op(1'b0, 16'h0100, 1'b0, 8'h00, 1'b0, "R9");

        repeat (12) @(negedge clk);
        chk(q.size() == 0, "R9", "pending completions", q.size(), 0);
        chk(!busy && rd_n && wr_n && !ad_oe, "R10", "bus idle at end",
            {busy, rd_n, wr_n, ad_oe}, 4'b0110);
        report();
    end

endmodule